// File: doc/BRIEF.md
# Signed-Digit Base-4 to Binary Converter

This block turns a number written in radix-4 signed digits into an ordinary two's-complement integer. Each input digit takes one of seven values, -3 through +3, and is held in its own 3-bit two's-complement field. An optional 2-bit signed carry digit sits one position above the most significant digit. The block decodes each digit, scales it by its power of four, and adds the results together with the scaled carry to form one binary result.

It is used wherever a carry-free signed-digit adder hands its result back to binary logic. It is purely combinational and holds no state. The digit count is a parameter, and so is whether the carry input is used. A second output is raised whenever any field holds a code that is outside the legal digit set. An illegal code is still decoded by plain sign extension, so the numeric result stays defined.

Top module: `qsd_to_bin`

## Requirements
- R1: Digit i of `digits_i` occupies bits 3i+2 down to 3i, with digit 0 in the least significant bits. `value_o` equals the sum over all digits of digit_i × 4^i, plus the carry term.
- R2: Each digit field is read as a 3-bit two's-complement number. Codes 3'b101, 3'b110 and 3'b111 mean -3, -2 and -1. Codes 3'b000 through 3'b011 mean 0 through +3.
- R3: When the carry is enabled, the carry code 2'b01 adds 4^NDIG to the result, 2'b11 subtracts 4^NDIG, and 2'b00 adds nothing. With NDIG=4 the step is 256.
- R4: `value_o` is 2·NDIG+3 bits wide. The legal extremes ±(2·4^NDIG − 1), which are ±511 for NDIG=4, come out exactly, with no overflow.
- R5: The digit code 3'b100 in any field raises `illegal_o`. That field then contributes -4 × 4^i to `value_o`.
- R6: The carry code 2'b10 raises `illegal_o`. It then contributes -2 × 4^NDIG to `value_o`.
- R7: The block holds no state. `value_o` and `illegal_o` follow an input change without any clock edge.
- R8: All-zero digits with a zero carry give `value_o` = 0 and `illegal_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| digits_i | input | 3·NDIG | Packed signed digits; digit 0 in bits 2:0 |
| carry_i | input | 2 | Signed carry digit at weight 4^NDIG |
| value_o | output | 2·NDIG+3 | Two's-complement result |
| illegal_o | output | 1 | High when any digit is 3'b100 or the carry is 2'b10 |

## Verification
Every time the inputs change, the assertions check four things:
- each legal decoded digit lies in -3..+3, and an illegal one decodes to -4;
- each carry code maps to its signed multiple of 4^NDIG;
- a bad carry always reaches `illegal_o`;
- whenever no code is illegal, the result stays inside the legal range.

Only the bench scenarios can show that the whole weighted sum is correct. These scenarios cover:
- the placement of each field;
- the positive and negative extremes;
- that a change shows up at the outputs with no clock edge;
- agreement with an integer reference model over many random legal vectors.

// File: rtl/qsd_conv_pkg.sv
package qsd_conv_pkg;
    localparam logic [2:0] DIGIT_BAD_CODE = 3'b100;
    localparam logic [1:0] CARRY_BAD_CODE = 2'b10;
    localparam int         DIGIT_BITS     = 3;
    localparam int         CARRY_BITS     = 2;

    function automatic int result_width(input int ndig);
        return 2 * ndig + 3;
    endfunction
endpackage

// File: rtl/qsd_digit_decode.sv
module qsd_digit_decode
    import qsd_conv_pkg::*;
#(
    parameter int OW = 11
) (
    input  logic [DIGIT_BITS-1:0] code_i,
    output logic signed [OW-1:0]  value_o,
    output logic                  bad_o
);
    always_comb begin
        value_o = OW'($signed(code_i));
        bad_o   = (code_i == DIGIT_BAD_CODE);
    end

    always_comb begin
        if (!bad_o) begin
            // R2
            digit_range_chk: assert (value_o >= -3 && value_o <= 3);
        end else begin
            // R5
            bad_digit_value_chk: assert (value_o == -4);
        end
    end
endmodule

// File: rtl/qsd_carry_decode.sv
module qsd_carry_decode
    import qsd_conv_pkg::*;
#(
    parameter int NDIG = 4,
    parameter int OW   = 11
) (
    input  logic [CARRY_BITS-1:0] code_i,
    output logic signed [OW-1:0]  weighted_o,
    output logic                  bad_o
);
    localparam int SHIFT = 2 * NDIG;

    logic signed [OW-1:0] extended;

    always_comb begin
        extended   = OW'($signed(code_i));
        weighted_o = extended <<< SHIFT;
        bad_o      = (code_i == CARRY_BAD_CODE);
    end

    always_comb begin
        if (code_i == 2'b01) begin
            // R3
            carry_plus_chk: assert (weighted_o == (OW'(1) <<< SHIFT));
        end
        if (code_i == 2'b11) begin
            // R3
            carry_minus_chk: assert (weighted_o == -(OW'(1) <<< SHIFT));
        end
    end
endmodule

// File: rtl/qsd_to_bin.sv
module qsd_to_bin
    import qsd_conv_pkg::*;
#(
    parameter int NDIG      = 4,
    parameter bit HAS_CARRY = 1'b1
) (
    input  logic [3*NDIG-1:0]        digits_i,
    input  logic [1:0]               carry_i,
    output logic signed [2*NDIG+2:0] value_o,
    output logic                     illegal_o
);
    localparam int OW    = result_width(NDIG);
    localparam int LIMIT = 2 * (4 ** NDIG) - 1;

    logic signed [OW-1:0] dig_val [NDIG];
    logic signed [OW-1:0] psum    [NDIG+1];
    logic [NDIG-1:0]      dig_bad;
    logic signed [OW-1:0] car_val;
    logic                 car_bad;

    assign psum[0] = '0;

    for (genvar i = 0; i < NDIG; i++) begin : g_digit
        qsd_digit_decode #(.OW(OW)) i_dec (
            .code_i  (digits_i[DIGIT_BITS*i +: DIGIT_BITS]),
            .value_o (dig_val[i]),
            .bad_o   (dig_bad[i])
        );
        assign psum[i+1] = psum[i] + (dig_val[i] <<< (2 * i));
    end

    if (HAS_CARRY) begin : g_carry
        qsd_carry_decode #(.NDIG(NDIG), .OW(OW)) i_car (
            .code_i     (carry_i),
            .weighted_o (car_val),
            .bad_o      (car_bad)
        );
    end else begin : g_nocarry
        assign car_val = '0;
        assign car_bad = 1'b0;
    end

    assign value_o   = psum[NDIG] + car_val;
    assign illegal_o = (|dig_bad) | car_bad;

    always_comb begin
        if (!illegal_o) begin
            // R4
            no_overflow_chk: assert (value_o <= LIMIT && value_o >= -LIMIT);
        end
        if (HAS_CARRY && carry_i == CARRY_BAD_CODE) begin
            // R6
            bad_carry_flag_chk: assert (illegal_o);
        end
    end
endmodule

// File: tb/test_qsd_to_bin.sv
module test_qsd_to_bin;
    localparam int NDIG = 4;
    localparam int OW   = 2 * NDIG + 3;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic [3*NDIG-1:0]     digits;
    logic [1:0]            carry;
    logic signed [OW-1:0]  value;
    logic                  illegal;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    qsd_to_bin #(.NDIG(NDIG), .HAS_CARRY(1'b1)) i_qsd_to_bin (
        .digits_i  (digits),
        .carry_i   (carry),
        .value_o   (value),
        .illegal_o (illegal)
    );

    function automatic int ref_value(logic [3*NDIG-1:0] d, logic [1:0] c);
        int acc = 0;
        for (int i = 0; i < NDIG; i++) begin
            int dv;
            dv  = int'($signed(d[3*i +: 3]));
            acc = acc + dv * (4 ** i);
        end
        acc = acc + int'($signed(c)) * (4 ** NDIG);
        return acc;
    endfunction

    task automatic check(string req, int exp_val, bit exp_bad);
        int got;
        got = int'(value);
        n_tests++;
        if (got != exp_val || illegal != exp_bad) begin
            n_fail++;
            $display("FAIL %s: value=%0d illegal=%0b expected value=%0d illegal=%0b",
                     req, got, illegal, exp_val, exp_bad);
        end
    endtask

    task automatic apply(logic [3*NDIG-1:0] d, logic [1:0] c);
        @(negedge clk);
        digits = d;
        carry  = c;
        #2;
    endtask

    // R8
    task automatic t_zero();
        apply('0, 2'b00);
        check("R8", 0, 1'b0);
    endtask

    // R1: a +1 in each position alone
    task automatic t_positions();
        for (int i = 0; i < NDIG; i++) begin
            logic [3*NDIG-1:0] d;
            d = '0;
            d[3*i +: 3] = 3'b001;
            apply(d, 2'b00);
            check("R1", 4 ** i, 1'b0);
        end
    endtask

    // R2: every legal digit code in digit 1
    task automatic t_codes();
        for (int v = -3; v <= 3; v++) begin
            logic [3*NDIG-1:0] d;
            d = '0;
            d[5:3] = 3'(v);
            apply(d, 2'b00);
            check("R2", v * 4, 1'b0);
        end
    endtask

    // R3
    task automatic t_carry();
        apply(12'h001, 2'b01);
        check("R3", 257, 1'b0);
        apply(12'h001, 2'b11);
        check("R3", -255, 1'b0);
        apply(12'h001, 2'b00);
        check("R3", 1, 1'b0);
    endtask

    // R4: all +3 with carry +1, and all -3 with carry -1
    task automatic t_extremes();
        apply({NDIG{3'b011}}, 2'b01);
        check("R4", 511, 1'b0);
        apply({NDIG{3'b101}}, 2'b11);
        check("R4", -511, 1'b0);
    endtask

    // R5 and R6
    task automatic t_illegal();
        apply(12'b000_100_000_000, 2'b00);
        check("R5", -64, 1'b1);
        apply(12'b000_000_000_100, 2'b00);
        check("R5", -4, 1'b1);
        apply(12'h000, 2'b10);
        check("R6", -512, 1'b1);
    endtask

    // R7: change between clock edges, look before the next edge
    task automatic t_comb();
        @(posedge clk);
        #3;
        digits = 12'b011_000_000_000;
        carry  = 2'b00;
        #1;
        check("R7", 192, 1'b0);
        digits = 12'b000_000_000_110;
        #1;
        check("R7", -2, 1'b0);
    endtask

    // R1 R2 R3: random legal vectors against the integer model
    task automatic t_random();
        for (int k = 0; k < 300; k++) begin
            logic [3*NDIG-1:0] d;
            logic [1:0] c;
            for (int i = 0; i < NDIG; i++)
                d[3*i +: 3] = 3'(int'($urandom_range(6)) - 3);
            c = 2'(int'($urandom_range(2)) - 1);
            apply(d, c);
            check("R1/R2/R3 random", ref_value(d, c), 1'b0);
        end
    endtask

    initial begin
        digits = '0;
        carry  = '0;
        #1;
        t_zero();
        t_positions();
        t_codes();
        t_carry();
        t_extremes();
        t_illegal();
        t_comb();
        t_random();
        t_zero();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: value=timeout expected value=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule